// File: doc/BRIEF.md
# Frame Metadata Header Inserter

This block sits on a byte-wide AXI4-Stream transmit path and adds an 8-byte offload header to every outgoing Ethernet frame. The header goes in right after the two MAC addresses (the first 12 bytes). It tells a downstream crypto engine how to treat the frame. The header carries a fixed marker ethertype, a one-byte operation code, the reciprocal of the segment size, the low half of the first TCP sequence number and the ESP next-protocol value. The frame's own ethertype then follows the header, together with the rest of the frame, unchanged.

A per-frame sideband supplies the header fields. The block samples the sideband on the first accepted byte of each frame. While it emits the 8 header bytes it holds off the upstream source. Backpressure from the sink is honoured at every byte. A frame that ends within its first 12 bytes is too short to hold the insertion point, and it passes through unmodified.

Top module: `frame_meta_inserter`

## Requirements
- R1: Output bytes 0 to 11 of a frame equal input bytes 0 to 11, in order.
- R2: Output bytes 12 and 13 carry the parameter META_ETYPE, most significant byte first (default 0x8CE4).
- R3: Output byte 14 is the operation code: 0x08 when the frame's sampled large-send flag is 0, and 0x09 when it is 1.
- R4: For a large-send frame, bytes 15 and 16 carry the 16-bit MSS reciprocal and bytes 17 and 18 carry the 16-bit low sequence value, both big-endian. For any other frame, bytes 15 to 18 are zero.
- R5: Output byte 19 carries the 8-bit ESP next-protocol value.
- R6: From output byte 20 onward the output repeats input byte 12 onward, the original ethertype first. The output frame is exactly 8 bytes longer than the input, and m_last is high only on its final byte.
- R7: The sideband is sampled on the first accepted byte of a frame. Changes to it later in the same frame have no effect on that frame's header.
- R8: While m_valid is high and m_ready is low, m_valid, m_data and m_last hold their values. No byte is lost or duplicated under any stall pattern on either side.
- R9: A frame whose s_last arrives within its first 12 bytes is passed unchanged, with no header, and the following frame is processed normally.
- R10: After reset, m_valid is low and the block waits for the first byte of a new frame, whatever point it had reached in a frame before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted when high with s_valid |
| s_data | input | 8 | Input frame byte |
| s_last | input | 1 | Final byte of the input frame |
| s_lso | input | 1 | Sideband: large-send frame flag |
| s_mss_recip | input | 16 | Sideband: reciprocal of the segment size, fixed point |
| s_seq_lo | input | 16 | Sideband: low 16 bits of the first TCP sequence number |
| s_next_proto | input | 8 | Sideband: ESP next-protocol value |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 8 | Output frame byte |
| m_last | output | 1 | Final byte of the output frame |

## Verification
The bench targets the boundary at byte 12. It uses frames of 13 bytes (one byte after the insertion point) and runt frames of 5 and exactly 12 bytes. A design that got the boundary wrong would drop or repeat the original ethertype, or would wrongly add a header to a runt frame. Every sideband field is scrambled after the first byte of each frame, so a design that samples the sideband late would emit a corrupted header. Stalls on either side fall inside the header window to expose lost or repeated header bytes. A reset in the middle of the header checks that the next frame does not continue the old header count.

// File: rtl/hdr_ins_pkg.sv
package hdr_ins_pkg;

   localparam int BYTE_W    = 8;
   localparam int HDR_BYTES = 8;
   localparam int HB_W      = $clog2(HDR_BYTES);

   typedef enum logic [1:0] {
      ST_ADDR,
      ST_HDR,
      ST_BODY
   } phase_t;

   typedef struct packed {
      logic        lso;
      logic [15:0] mss_recip;
      logic [15:0] seq_lo;
      logic [7:0]  next_proto;
   } meta_t;

   function automatic logic [BYTE_W-1:0] hdr_byte(
      input logic [HB_W-1:0] pos,
      input meta_t           m,
      input logic [15:0]     etype,
      input logic [7:0]      syn_plain,
      input logic [7:0]      syn_lso
   );
      logic [BYTE_W-1:0] b;
      case (pos)
         3'd0:    b = etype[15:8];
         3'd1:    b = etype[7:0];
         3'd2:    b = m.lso ? syn_lso : syn_plain;
         3'd3:    b = m.lso ? m.mss_recip[15:8] : 8'h00;
         3'd4:    b = m.lso ? m.mss_recip[7:0]  : 8'h00;
         3'd5:    b = m.lso ? m.seq_lo[15:8]    : 8'h00;
         3'd6:    b = m.lso ? m.seq_lo[7:0]     : 8'h00;
         default: b = m.next_proto;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/hdr_ins_seq.sv
module hdr_ins_seq
   import hdr_ins_pkg::*;
#(
   parameter int MAC_BYTES = 12,
   parameter int IDX_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             s_last,
   input  meta_t            meta_in,
   output phase_t           phase,
   output logic [IDX_W-1:0] idx,
   output meta_t            meta_q
);

   localparam logic [IDX_W-1:0] ADDR_END = IDX_W'(MAC_BYTES - 1);
   localparam logic [IDX_W-1:0] HDR_END  = IDX_W'(HDR_BYTES - 1);

   phase_t           phase_n;
   logic [IDX_W-1:0] idx_n;

   always_comb begin
      phase_n = phase;
      idx_n   = idx;
      if (adv) begin
         case (phase)
            ST_ADDR: begin
               if (s_last) begin
                  idx_n = '0;
               end else if (idx == ADDR_END) begin
                  phase_n = ST_HDR;
                  idx_n   = '0;
               end else begin
                  idx_n = idx + IDX_W'(1);
               end
            end
            ST_HDR: begin
               if (idx == HDR_END) begin
                  phase_n = ST_BODY;
                  idx_n   = '0;
               end else begin
                  idx_n = idx + IDX_W'(1);
               end
            end
            default: begin
               if (s_last) phase_n = ST_ADDR;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= ST_ADDR;
         idx    <= '0;
         meta_q <= '0;
      end else begin
         phase <= phase_n;
         idx   <= idx_n;
         if (adv && phase == ST_ADDR && idx == '0)
            meta_q <= meta_in;
      end
   end

   // R9
   runt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_ADDR && adv && s_last) |=> (phase == ST_ADDR && idx == '0));

   // R6
   hdr_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_HDR && adv && idx == HDR_END) |=> (phase == ST_BODY));

   // R7
   meta_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != ST_ADDR) |=> $stable(meta_q));

   // R1
   addr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_ADDR) |-> (idx <= ADDR_END));

endmodule

// File: rtl/hdr_ins_mux.sv
module hdr_ins_mux
   import hdr_ins_pkg::*;
#(
   parameter logic [15:0] META_ETYPE = 16'h8CE4,
   parameter logic [7:0]  SYN_PLAIN  = 8'h08,
   parameter logic [7:0]  SYN_LSO    = 8'h09
) (
   input  phase_t            phase,
   input  logic [HB_W-1:0]   hpos,
   input  meta_t             meta_q,
   input  logic              s_valid,
   input  logic [BYTE_W-1:0] s_data,
   input  logic              s_last,
   output logic              s_ready,
   output logic              c_valid,
   output logic [BYTE_W-1:0] c_data,
   output logic              c_last,
   input  logic              c_ready
);

   always_comb begin
      if (phase == ST_HDR) begin
         c_valid = 1'b1;
         c_data  = hdr_byte(hpos, meta_q, META_ETYPE, SYN_PLAIN, SYN_LSO);
         c_last  = 1'b0;
         s_ready = 1'b0;
      end else begin
         c_valid = s_valid;
         c_data  = s_data;
         c_last  = s_last;
         s_ready = c_ready;
      end
   end

endmodule

// File: rtl/hdr_ins_oreg.sv
module hdr_ins_oreg
   import hdr_ins_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              i_valid,
   input  logic [BYTE_W-1:0] i_data,
   input  logic              i_last,
   output logic              i_ready,
   output logic              o_valid,
   output logic [BYTE_W-1:0] o_data,
   output logic              o_last,
   input  logic              o_ready
);

   assign i_ready = !o_valid || o_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_valid <= 1'b0;
         o_data  <= '0;
         o_last  <= 1'b0;
      end else if (i_ready) begin
         o_valid <= i_valid;
         o_data  <= i_data;
         o_last  <= i_last;
      end
   end

   // R8
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && !o_ready) |=> (o_valid && $stable(o_data) && $stable(o_last)));

endmodule

// File: rtl/frame_meta_inserter.sv
module frame_meta_inserter
   import hdr_ins_pkg::*;
#(
   parameter int          MAC_BYTES  = 12,
   parameter logic [15:0] META_ETYPE = 16'h8CE4,
   parameter logic [7:0]  SYN_PLAIN  = 8'h08,
   parameter logic [7:0]  SYN_LSO    = 8'h09,
   parameter bit          OUT_REG    = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        s_valid,
   output logic        s_ready,
   input  logic [7:0]  s_data,
   input  logic        s_last,
   input  logic        s_lso,
   input  logic [15:0] s_mss_recip,
   input  logic [15:0] s_seq_lo,
   input  logic [7:0]  s_next_proto,
   output logic        m_valid,
   input  logic        m_ready,
   output logic [7:0]  m_data,
   output logic        m_last
);

   localparam int CNT_MAX = (MAC_BYTES > HDR_BYTES) ? MAC_BYTES : HDR_BYTES;
   localparam int IDX_W   = $clog2(CNT_MAX + 1);

   if (MAC_BYTES < 1) begin : g_bad_mac
      $error("MAC_BYTES must be at least 1");
   end
   if (SYN_PLAIN == SYN_LSO) begin : g_bad_syn
      $error("operation codes must differ");
   end

   phase_t            phase;
   logic [IDX_W-1:0]  idx;
   meta_t             meta_in, meta_q;
   logic              c_valid, c_last, c_ready;
   logic [BYTE_W-1:0] c_data;

   assign meta_in = '{lso: s_lso, mss_recip: s_mss_recip,
                      seq_lo: s_seq_lo, next_proto: s_next_proto};

   hdr_ins_seq #(.MAC_BYTES(MAC_BYTES), .IDX_W(IDX_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (c_valid && c_ready),
      .s_last  (s_last),
      .meta_in (meta_in),
      .phase   (phase),
      .idx     (idx),
      .meta_q  (meta_q)
   );

   hdr_ins_mux #(.META_ETYPE(META_ETYPE), .SYN_PLAIN(SYN_PLAIN), .SYN_LSO(SYN_LSO)) u_mux (
      .phase   (phase),
      .hpos    (idx[HB_W-1:0]),
      .meta_q  (meta_q),
      .s_valid (s_valid),
      .s_data  (s_data),
      .s_last  (s_last),
      .s_ready (s_ready),
      .c_valid (c_valid),
      .c_data  (c_data),
      .c_last  (c_last),
      .c_ready (c_ready)
   );

   if (OUT_REG) begin : g_reg
      hdr_ins_oreg u_oreg (
         .clk     (clk),
         .rst_n   (rst_n),
         .i_valid (c_valid),
         .i_data  (c_data),
         .i_last  (c_last),
         .i_ready (c_ready),
         .o_valid (m_valid),
         .o_data  (m_data),
         .o_last  (m_last),
         .o_ready (m_ready)
      );
   end else begin : g_comb
      assign m_valid = c_valid;
      assign m_data  = c_data;
      assign m_last  = c_last;
      assign c_ready = m_ready;
   end

   // R3
   syndrome_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_HDR && idx == IDX_W'(2)) |-> (c_data == SYN_PLAIN || c_data == SYN_LSO));

   // R6
   no_last_in_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_HDR) |-> (c_valid && !c_last && !s_ready));

endmodule

// File: tb/tb_frame_meta_inserter.sv
module tb_frame_meta_inserter;

   localparam logic [15:0] ETYPE = 16'h8CE4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_valid = 1'b0, s_ready, s_last = 1'b0;
   logic [7:0]  s_data = '0;
   logic        s_lso = 1'b0;
   logic [15:0] s_mss_recip = '0, s_seq_lo = '0;
   logic [7:0]  s_next_proto = '0;
   logic        m_valid, m_ready = 1'b0, m_last;
   logic [7:0]  m_data;

   int checks = 0, fails = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   frame_meta_inserter #(.META_ETYPE(ETYPE)) dut (.*);

   typedef struct packed {
      logic [15:0] len;
      logic        lso;
      logic [15:0] mss;
      logic [15:0] seq;
      logic [7:0]  nxt;
      logic [3:0]  sg;
      logic [3:0]  rg;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t TBL [NV] = '{
      '{16'd60,  1'b0, 16'h1234, 16'hABCD, 8'h32, 4'd0, 4'd0},
      '{16'd64,  1'b1, 16'h0020, 16'hBEEF, 8'h06, 4'd0, 4'd0},
      '{16'd13,  1'b1, 16'hFFFF, 16'h0001, 8'h11, 4'd3, 4'd0},
      '{16'd100, 1'b1, 16'h0555, 16'h8000, 8'h04, 4'd0, 4'd3},
      '{16'd40,  1'b0, 16'h0000, 16'h0000, 8'h29, 4'd2, 4'd2},
      '{16'd20,  1'b1, 16'h00C8, 16'h7FFF, 8'h06, 4'd5, 4'd4}
   };

   function automatic logic [7:0] pay(int f, int i);
      return 8'(i * 29 + f * 17 + 3);
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic run_frame(int f, vec_t v);
      logic [7:0] got[$];
      int sent = 0, cyc = 0, hold_bad = 0, len = int'(v.len);
      bit done = 1'b0, prev_stall = 1'b0, prev_l = 1'b0;
      logic [7:0] prev_d = '0;
      int exp_len;
      string rq [7];
      int bad_act [7], bad_exp [7];
      bit bad [7];
      while (!done && cyc < 4000) begin
         @(posedge clk); #1;
         s_valid = (sent < len) && (v.sg == 0 || (cyc % int'(v.sg)) != 0);
         s_data  = pay(f, sent);
         s_last  = (sent == len - 1);
         // R7: sideband scrambled after the first byte
         s_lso        = (sent == 0) ? v.lso : ~v.lso;
         s_mss_recip  = (sent == 0) ? v.mss : ~v.mss;
         s_seq_lo     = (sent == 0) ? v.seq : ~v.seq;
         s_next_proto = (sent == 0) ? v.nxt : ~v.nxt;
         m_ready = (v.rg == 0 || (cyc % int'(v.rg)) != 0);
         @(negedge clk);
         if (prev_stall && !(m_valid && m_data == prev_d && m_last == prev_l))
            hold_bad++;
         prev_stall = m_valid && !m_ready;
         prev_d = m_data;
         prev_l = m_last;
         if (s_valid && s_ready) sent++;
         if (m_valid && m_ready) begin
            got.push_back(m_data);
            if (m_last) done = 1'b1;
         end
         cyc++;
      end
      @(posedge clk); #1;
      s_valid = 1'b0;
      m_ready = 1'b0;
      exp_len = (len > 12) ? len + 8 : len;
      chk(done && got.size() == exp_len, "R6", "frame length", got.size(), exp_len);
      chk(hold_bad == 0, "R8", "stall hold violations", hold_bad, 0);
      foreach (bad[k]) bad[k] = 1'b0;
      for (int j = 0; j < got.size() && j < exp_len; j++) begin
         logic [7:0] e;
         int r;
         if (len <= 12) begin
            e = pay(f, j); r = 6;
         end else if (j < 12) begin
            e = pay(f, j); r = 0;
         end else if (j < 14) begin
            e = (j == 12) ? ETYPE[15:8] : ETYPE[7:0]; r = 1;
         end else if (j == 14) begin
            e = v.lso ? 8'h09 : 8'h08; r = 2;
         end else if (j < 19) begin
            case (j)
               15: e = v.mss[15:8];
               16: e = v.mss[7:0];
               17: e = v.seq[15:8];
               default: e = v.seq[7:0];
            endcase
            if (!v.lso) e = 8'h00;
            r = 3;
         end else if (j == 19) begin
            e = v.nxt; r = 4;
         end else begin
            e = pay(f, j - 8); r = 5;
         end
         if (got[j] != e && !bad[r]) begin
            bad[r] = 1'b1; bad_act[r] = got[j]; bad_exp[r] = e;
         end
      end
      rq = '{"R1", "R2", "R3", "R4", "R5", "R6", "R9"};
      if (len <= 12) begin
         chk(!bad[6], "R9", "runt byte", bad_act[6], bad_exp[6]);
      end else begin
         for (int r = 0; r < 6; r++)
            chk(!bad[r], rq[r], $sformatf("frame %0d bytes", f), bad_act[r], bad_exp[r]);
         chk(!(bad[2] || bad[3] || bad[4]), "R7", "header from first-beat sideband", 0, 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      vec_t v;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(m_valid == 1'b0, "R10", "m_valid in reset", m_valid, 0);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      chk(m_valid == 1'b0, "R10", "m_valid after reset", m_valid, 0);

      for (int i = 0; i < NV; i++) run_frame(i, TBL[i]);

      // R9: runts of 5 and exactly 12 bytes, then a normal frame
      v = '{16'd5, 1'b1, 16'h1111, 16'h2222, 8'h33, 4'd0, 4'd2};
      run_frame(10, v);
      v.len = 16'd12;
      run_frame(11, v);
      v = '{16'd30, 1'b0, 16'h4444, 16'h5555, 8'h66, 4'd0, 4'd0};
      run_frame(12, v);

      // R10: reset in the middle of a header
      for (int c = 0; c < 15; c++) begin
         @(posedge clk); #1;
         s_valid = 1'b1; s_data = 8'hEE; s_last = 1'b0; m_ready = 1'b1;
      end
      @(posedge clk); #1;
      s_valid = 1'b0; m_ready = 1'b0; rst_n = 1'b0;
      @(negedge clk);
      chk(m_valid == 1'b0, "R10", "m_valid during mid-frame reset", m_valid, 0);
      @(posedge clk); #1 rst_n = 1'b1;
      v = '{16'd25, 1'b1, 16'h0ABC, 16'h0DEF, 8'h32, 4'd2, 4'd0};
      run_frame(13, v);

      // back-to-back frames with stalls on both sides
      v = '{16'd14, 1'b0, 16'h7777, 16'h8888, 8'h99, 4'd0, 4'd2};
      run_frame(14, v);
      v = '{16'd16, 1'b1, 16'hCAFE, 16'hF00D, 8'h01, 4'd2, 4'd3};
      run_frame(15, v);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule